// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of asynchronous input pins, organised as three groups of eight bit positions. Every pin first passes through a synchronizer. A change in either direction on a pin that software has unmasked latches a sticky per-group flag. Each group then raises an interrupt request while its flag is set and the group is enabled. In the middle group only seven pins exist: the top position of that group has no pin, and its mask bit is tied off.

Software reaches the controller through a byte-wide register port. Writes take effect on the clock edge, and reads are combinational from the address. The map is as follows. Offset 0 holds the group enables, one bit per group, with bit g belonging to group g. Offset 1 holds the group flags, which are cleared by writing 1. Offsets 2, 3 and 4 hold the mask registers of groups 0, 1 and 2. Any other offset reads as zero.

Top module: `pin_change_irq`

## Requirements
- R1: Group g is fed by pin_in[8g+7:8g], so group 0 covers pins 0–7, group 1 covers pins 8–15 and group 2 covers pins 16–23. Group g's flag is bit g of offset 1, and group g's request is irq[g].
- R2: The enable register at offset 0 stores bits [2:0] of a write. It reads back with bits [7:3] as zero.
- R3: The mask registers of groups 0, 1 and 2 sit at offsets 2, 3 and 4, and each reads back what was written to it.
- R4: Pin 15 is not implemented. Bit 7 of the group-1 mask always reads 0, and toggling pin_in[15] never sets a flag.
- R5: A rise or a fall on an unmasked pin sets its group's flag. The flag is visible on the third rising clock edge after the pin changes: two edges pass through the synchronizer and one more goes to the flag.
- R6: A change on a pin whose mask bit is 0 leaves its group's flag unchanged.
- R7: Writing 1 to a flag bit at offset 1 clears that flag. Writing 0 to a flag bit has no effect on it. If a set and a clear of the same flag fall on the same edge, the set wins.
- R8: irq[g] equals flag g AND enable g. A disabled group still sets its flag when a qualifying change occurs.
- R9: Changes on several unmasked pins of one group set that group's single flag and touch no other group's flag.
- R10: After reset, every register, every flag and every request is 0.
- R11: Offsets 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | Asynchronous monitored pins |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 3 | Per-group interrupt request |

## Verification
The bench builds the block with its default parameters: three groups, a two-stage synchronizer and an implementation map that removes pin 15. With these values the gap in the middle group, the three-edge detection latency and the unmapped offsets 5 to 7 are all within reach. Directed cases cover rises and falls, masked pins, a set and a clear on the same edge, and disabled groups. A long random run of sparse pin toggles interleaved with random register writes is checked every cycle against a bench model of the flags and requests.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int GRP_W         = 8;
    localparam int REG_CTRL      = 0;
    localparam int REG_FLAG      = 1;
    localparam int REG_MASK_BASE = 2;

    typedef logic [GRP_W-1:0] grp_vec_t;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcint_group.sv
module pcint_group
    import pcint_pkg::*;
#(
    parameter grp_vec_t IMPL = '1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  grp_vec_t pins_sync,
    input  grp_vec_t mask,
    input  logic     clr,
    output logic     flag
);
    typedef struct packed {
        grp_vec_t prev;
        logic     flag;
    } grp_state_t;

    grp_state_t st_d, st_q;
    grp_vec_t   chg;

    always_comb begin
        chg       = (pins_sync ^ st_q.prev) & mask & IMPL;
        st_d      = st_q;
        st_d.prev = pins_sync;
        st_d.flag = (st_q.flag & ~clr) | (|chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R5 / R6: a flag only rises after an unmasked, implemented pin moved
    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(|((pins_sync ^ st_q.prev) & mask & IMPL)));

    // R7: a flag only falls after a clear request
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcint_pkg::*;
#(
    parameter int                         NUM_GROUPS  = 3,
    parameter int                         SYNC_STAGES = 2,
    parameter int                         ADDR_W      = 3,
    parameter logic [NUM_GROUPS*GRP_W-1:0] IMPL_MAP   = 24'hFF7FFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*GRP_W-1:0] pin_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic [NUM_GROUPS-1:0]       irq
);
    localparam int NPINS    = NUM_GROUPS * GRP_W;
    localparam int LAST_REG = REG_MASK_BASE + NUM_GROUPS - 1;

    typedef struct packed {
        logic [NUM_GROUPS-1:0]           en;
        logic [NUM_GROUPS-1:0][GRP_W-1:0] mask;
    } cfg_state_t;

    cfg_state_t            st_d, st_q;
    logic [NPINS-1:0]      pins_sync;
    logic [NUM_GROUPS-1:0] clr_req;
    logic [NUM_GROUPS-1:0] flags;

    pcint_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pins_sync)
    );

    always_comb begin
        st_d    = st_q;
        clr_req = '0;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(REG_CTRL)) st_d.en = bus_wdata[NUM_GROUPS-1:0];
            if (bus_addr == ADDR_W'(REG_FLAG)) clr_req = bus_wdata[NUM_GROUPS-1:0];
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (bus_addr == ADDR_W'(REG_MASK_BASE + g))
                    st_d.mask[g] = bus_wdata & IMPL_MAP[g*GRP_W +: GRP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            pcint_group #(.IMPL(IMPL_MAP[g*GRP_W +: GRP_W])) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .pins_sync(pins_sync[g*GRP_W +: GRP_W]),
                .mask     (st_q.mask[g]),
                .clr      (clr_req[g]),
                .flag     (flags[g])
            );

            // R4: unimplemented mask positions never hold a 1
            assert_mask_impl_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.mask[g] & ~IMPL_MAP[g*GRP_W +: GRP_W]) == '0);
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL)) bus_rdata[NUM_GROUPS-1:0] = st_q.en;
        if (bus_addr == ADDR_W'(REG_FLAG)) bus_rdata[NUM_GROUPS-1:0] = flags;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(REG_MASK_BASE + g)) bus_rdata = st_q.mask[g];
        end
    end

    assign irq = flags & st_q.en;

    // R11: offsets past the last register read as zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(LAST_REG)) |-> (bus_rdata == 8'h00));

    // R2: the enables change only on a write to the control offset
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(REG_CTRL)) |=> $stable(st_q.en));

    // R8: a request implies the group's flag is set
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flags) == '0);
endmodule

// File: tb/sim_pin_change_irq.sv
`timescale 1ns/100ps
module sim_pin_change_irq;
    localparam logic [23:0] IMPL = 24'hFF7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [2:0]  m_en = '0, m_flag = '0;
    logic [7:0]  m_mask [3] = '{default: 8'h00};

    always #2.5 clk = ~clk;

    pin_change_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {5'b0, m_en};
            3'd1: return {5'b0, m_flag};
            3'd2: return m_mask[0];
            3'd3: return m_mask[1];
            3'd4: return m_mask[2];
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input logic [23:0] p, input logic we, input logic [2:0] a,
                        input logic [7:0] d, input string tag);
        logic [2:0] nf;
        @(negedge clk);
        pin_in = p; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        for (int g = 0; g < 3; g++) begin
            logic [7:0] c;
            logic       clr;
            c     = (m_s2[g*8 +: 8] ^ m_prev[g*8 +: 8]) & m_mask[g] & IMPL[g*8 +: 8];
            clr   = we && a == 3'd1 && d[g];
            nf[g] = (m_flag[g] & ~clr) | (|c);
        end
        if (we && a == 3'd0) m_en = d[2:0];
        if (we && a >= 3'd2 && a <= 3'd4) m_mask[a-2] = d & IMPL[(a-2)*8 +: 8];
        m_prev = m_s2; m_s2 = m_s1; m_s1 = p; m_flag = nf;
        #1;
        bus_we = 1'b0;
        chk({tag, " irq (R8)"}, {5'b0, irq}, {5'b0, m_flag & m_en});
        bus_addr = 3'd1;
        #0.2;
        chk({tag, " flags"}, bus_rdata, exp_read(3'd1));
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            #0.1;
            chk(tag, bus_rdata, exp_read(3'(a)));
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(pin_in, 1'b0, 3'd0, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] p;
        void'($urandom(32'd1234));
        #12 rst_n = 1'b1;
        @(negedge clk);
        read_all("R10 reset regs");
        chk("R10 reset irq", {5'b0, irq}, 8'h00);

        step('0, 1'b1, 3'd0, 8'hFF, "R2 write ctrl");
        step('0, 1'b1, 3'd2, 8'hFF, "R3 mask0");
        step('0, 1'b1, 3'd3, 8'hFF, "R4 mask1");
        step('0, 1'b1, 3'd4, 8'hA5, "R3 mask2");
        #0.1; read_all("R2 R3 R4 readback");
        chk("R4 mask1 bit7", {7'b0, exp_read(3'd3) == 8'h7F}, 8'h01);

        // R5 latency: rise on pin 3
        step(24'h000008, 1'b0, 3'd0, 8'h00, "R5 rise");
        chk("R5 not yet at edge 1", {5'b0, m_flag}, 8'h00);
        idle(1, "R5");
        chk("R5 not yet at edge 2", bus_rdata, 8'h00);
        idle(1, "R5");
        chk("R5 visible at edge 3", bus_rdata, 8'h01);
        step(pin_in, 1'b1, 3'd1, 8'h01, "R7 clear g0");
        chk("R7 cleared", bus_rdata, 8'h00);
        // R5 fall
        step(24'h000000, 1'b0, 3'd0, 8'h00, "R5 fall");
        idle(3, "R5 fall");
        chk("R5 fall sets flag", bus_rdata, 8'h01);
        step(pin_in, 1'b1, 3'd1, 8'h06, "R7 write other bits");
        chk("R7 write 1 to clear flags keeps g0", bus_rdata, 8'h01);
        step(pin_in, 1'b1, 3'd1, 8'h00, "R7 write 0");
        chk("R7 write 0 no effect", bus_rdata, 8'h01);
        step(pin_in, 1'b1, 3'd1, 8'h07, "R7 clear all");

        // R4 pin 15
        step(24'h008000, 1'b0, 3'd0, 8'h00, "R4 pin15");
        idle(4, "R4 pin15");
        chk("R4 pin15 no flag", bus_rdata, 8'h00);
        // R6 masked pin of group 2 (mask A5, bit 1 masked -> pin 17)
        step(24'h028000, 1'b0, 3'd0, 8'h00, "R6 masked");
        idle(4, "R6 masked");
        chk("R6 masked no flag", bus_rdata, 8'h00);
        // R9 several pins in group 1, R1 group mapping
        step(24'h02FF00 ^ 24'h008000, 1'b0, 3'd0, 8'h00, "R9 multi");
        idle(3, "R9 multi");
        chk("R9 R1 only group1 flag", bus_rdata, 8'h02);
        // R7 set wins over simultaneous clear
        step(24'h020000 | 24'h008000, 1'b0, 3'd0, 8'h00, "R7 set/clr");
        idle(1, "R7 set/clr");
        step(pin_in, 1'b1, 3'd1, 8'h02, "R7 set/clr same edge");
        chk("R7 set wins", bus_rdata, 8'h02);
        // R8 disabled group still flags
        step(pin_in, 1'b1, 3'd0, 8'h00, "R8 disable");
        step(24'h020001 ^ 24'h008000 ^ 24'h008000, 1'b0, 3'd0, 8'h00, "R8 toggle");
        idle(3, "R8 disabled");
        chk("R8 flag without enable", bus_rdata, 8'h03);
        chk("R8 irq off", {5'b0, irq}, 8'h00);
        step(pin_in, 1'b1, 3'd0, 8'h01, "R8 enable g0");
        chk("R8 irq g0", {5'b0, irq}, 8'h01);
        // R11 unmapped
        step(pin_in, 1'b1, 3'd6, 8'hFF, "R11 write");
        #0.1; read_all("R11 regs unchanged");

        // random
        for (int i = 0; i < 3000; i++) begin
            p = pin_in;
            if ($urandom_range(0, 2) == 0) p = p ^ (24'd1 << $urandom_range(0, 23));
            if ($urandom_range(0, 9) == 0) p = p ^ 24'($urandom);
            if ($urandom_range(0, 3) == 0)
                step(p, 1'b1, 3'($urandom_range(0, 7)), 8'($urandom), "R5 R6 R7 random");
            else
                step(p, 1'b0, 3'd0, 8'h00, "R5 R6 R9 random");
            if (i % 200 == 0) begin #0.1; read_all("R2 R3 random readback"); end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule